// File: doc/BRIEF.md
# Eight-Pixel Group Hit Timer and Word Builder

This block serves one group of eight pixels, laid out as four rows by two columns, and sits above that group's readout node. The eight discriminator outputs, and an optional test-injection path, are merged into a hit-shape register. The first hit of a group starts a local time counter. A programmable clock-enable divider advances the counter and stands in for a gated oscillator, so the counter toggles only while a hit is pending.

A shared timing-reference pulse stops the measurement. At that point the block freezes a 20-bit word made of the group address, the time count and the hit shape, and raises a request to the readout node. It holds that word and request steady until the node answers with an acknowledge. The group then clears itself and is ready for the next hit.

Top module: `sp_hit_capture`

## Requirements
- R1: After reset, `req` is 0 and `word_out` is all zeros.
- R2: In idle, any nonzero merged hit vector starts a measurement and loads that vector into the shape field. Shape bit i is pixel i, counted row-major: row i/2, column i%2.
- R3: While the measurement runs, further hits are OR-ed into the shape field.
- R4: When `time_ref` is high during a measurement, the word freezes and `req` reads 1 after that edge. The word layout is `group_addr` sampled at that edge in [19:16], the count in [15:8] and the shape in [7:0].
- R5: The count starts at 0 and rises by one every `osc_div`+1 clock edges of the measurement. With the first hit at edge E0 and `time_ref` at edge Em, the frozen count is floor((m-1)/(`osc_div`+1)).
- R6: The count saturates at 255 and does not wrap.
- R7: While `req` is 1, new hits and new `time_ref` pulses leave `word_out` unchanged.
- R8: `req` stays 1 until `ack` is seen. The edge that sees `ack` returns the group to idle, with `req` at 0, the counter stopped and `word_out` at zero.
- R9: Pixel i is also hit when `test_en[i]`, `test_pulse` and `strobe` are all 1. A test pulse without the strobe has no effect.
- R10: In idle, `time_ref` and `ack` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| group_addr | input | 4 | Address of this group, captured when the word freezes |
| osc_div | input | 4 | Divider setting; one count per osc_div+1 cycles |
| disc_hit | input | 8 | Discriminator hit, one bit per pixel |
| test_en | input | 8 | Per-pixel test-injection enable |
| test_pulse | input | 1 | Test pulse |
| strobe | input | 1 | Strobe that qualifies the test pulse |
| time_ref | input | 1 | Timing reference that stops the measurement |
| ack | input | 1 | Acknowledge from the readout node |
| req | output | 1 | Request to the readout node |
| word_out | output | 20 | Address, time count and hit shape |

## Verification
The assertions assume that `ack` is only raised while `req` is high, or that an early `ack` is harmless, and that the node drops it within a cycle. They also assume that `group_addr` changes only while the group is idle. The stimulus pulses `ack` for exactly one cycle after a request has been observed. It sets `group_addr` before each hit. All inputs change on the falling clock edge, so every sample is unambiguous.

// File: rtl/sp_pkg.sv
package sp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_TIME = 2'd1,
    ST_REQ  = 2'd2
  } sp_state_e;
endpackage

// File: rtl/sp_hit_merge.sv
module sp_hit_merge #(
  parameter int N_PIX = 8
) (
  input  logic [N_PIX-1:0] disc_hit,
  input  logic [N_PIX-1:0] test_en,
  input  logic             test_pulse,
  input  logic             strobe,
  output logic [N_PIX-1:0] hit_any
);
  logic inject;
  assign inject = test_pulse & strobe;

  for (genvar i = 0; i < N_PIX; i++) begin : g_pix
    assign hit_any[i] = disc_hit[i] | (test_en[i] & inject);
  end
endmodule

// File: rtl/sp_osc_timer.sv
module sp_osc_timer #(
  parameter int TIME_W = 8,
  parameter int DIV_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              run,
  input  logic [DIV_W-1:0]  osc_div,
  output logic [TIME_W-1:0] count
);
  localparam logic [TIME_W-1:0] CNT_MAX = {TIME_W{1'b1}};

  logic [DIV_W-1:0] div_cnt;

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      div_cnt <= '0;
      count   <= '0;
    end else if (run) begin
      if (div_cnt == osc_div) begin
        div_cnt <= '0;
        if (count != CNT_MAX) count <= count + 1'b1;
      end else begin
        div_cnt <= div_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/sp_hit_capture.sv
module sp_hit_capture
  import sp_pkg::*;
#(
  parameter int N_PIX  = 8,
  parameter int ADDR_W = 4,
  parameter int TIME_W = 8,
  parameter int DIV_W  = 4
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic [ADDR_W-1:0]              group_addr,
  input  logic [DIV_W-1:0]               osc_div,
  input  logic [N_PIX-1:0]               disc_hit,
  input  logic [N_PIX-1:0]               test_en,
  input  logic                           test_pulse,
  input  logic                           strobe,
  input  logic                           time_ref,
  input  logic                           ack,
  output logic                           req,
  output logic [ADDR_W+TIME_W+N_PIX-1:0] word_out
);
  sp_state_e         state;
  logic [N_PIX-1:0]  hit_any;
  logic [N_PIX-1:0]  shape;
  logic [ADDR_W-1:0] addr_q;
  logic [TIME_W-1:0] t_count;
  logic              tmr_run;
  logic              tmr_clear;

  sp_hit_merge #(.N_PIX(N_PIX)) u_merge (
    .disc_hit   (disc_hit),
    .test_en    (test_en),
    .test_pulse (test_pulse),
    .strobe     (strobe),
    .hit_any    (hit_any)
  );

  assign tmr_run   = (state == ST_TIME) && !time_ref;
  assign tmr_clear = (state == ST_IDLE) || ((state == ST_REQ) && ack);

  sp_osc_timer #(.TIME_W(TIME_W), .DIV_W(DIV_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .clear   (tmr_clear),
    .run     (tmr_run),
    .osc_div (osc_div),
    .count   (t_count)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_IDLE;
      shape  <= '0;
      addr_q <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (|hit_any) begin
            shape <= hit_any;
            state <= ST_TIME;
          end
        end
        ST_TIME: begin
          shape <= shape | hit_any;
          if (time_ref) begin
            addr_q <= group_addr;
            state  <= ST_REQ;
          end
        end
        ST_REQ: begin
          if (ack) begin
            shape  <= '0;
            addr_q <= '0;
            state  <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req      = (state == ST_REQ);
  assign word_out = {addr_q, t_count, shape};
endmodule

// File: rtl/sp_hit_capture_chk.sv
module sp_hit_capture_chk #(
  parameter int N_PIX  = 8,
  parameter int ADDR_W = 4,
  parameter int TIME_W = 8
) (
  input logic                           clk,
  input logic                           rst,
  input logic                           req,
  input logic                           ack,
  input logic [ADDR_W+TIME_W+N_PIX-1:0] word_out
);
  logic [TIME_W-1:0] cnt_f;
  logic [N_PIX-1:0]  shape_f;
  assign cnt_f   = word_out[TIME_W+N_PIX-1:N_PIX];
  assign shape_f = word_out[N_PIX-1:0];

  assert_req_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (req && !ack) |=> req);

  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (rst)
    (req && ack) |=> (!req && word_out == '0));

  assert_frozen_word_R7: assert property (@(posedge clk) disable iff (rst)
    (req && !ack) |=> $stable(word_out));

  assert_no_wrap_R6: assert property (@(posedge clk) disable iff (rst)
    (cnt_f == {TIME_W{1'b1}} && !(req && ack)) |=> cnt_f == {TIME_W{1'b1}});

  assert_idle_stopped_R8: assert property (@(posedge clk) disable iff (rst)
    (!req && shape_f == '0) |-> cnt_f == '0);

  assert_req_has_hit_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(req) |-> shape_f != '0);
endmodule

bind sp_hit_capture sp_hit_capture_chk #(
  .N_PIX(N_PIX), .ADDR_W(ADDR_W), .TIME_W(TIME_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req      (req),
  .ack      (ack),
  .word_out (word_out)
);

// File: tb/sp_hit_capture_tb.sv
`timescale 1ns/1ps
module sp_hit_capture_tb;
  localparam real CYC = 8.0;

  logic        clk = 1'b0;
  logic        rst;
  logic [3:0]  group_addr;
  logic [3:0]  osc_div;
  logic [7:0]  disc_hit;
  logic [7:0]  test_en;
  logic        test_pulse;
  logic        strobe;
  logic        time_ref;
  logic        ack;
  logic        req;
  logic [19:0] word_out;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #(CYC/2) clk = ~clk;

  sp_hit_capture u_dut (
    .clk(clk), .rst(rst), .group_addr(group_addr), .osc_div(osc_div),
    .disc_hit(disc_hit), .test_en(test_en), .test_pulse(test_pulse),
    .strobe(strobe), .time_ref(time_ref), .ack(ack),
    .req(req), .word_out(word_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [19:0] mk(input logic [3:0] a, input int cnt, input logic [7:0] s);
    logic [7:0] c;
    c = (cnt > 255) ? 8'hFF : 8'(cnt);
    return {a, c, s};
  endfunction

  task automatic do_ack();
    ack = 1'b1;
    @(negedge clk);
    ack = 1'b0;
  endtask

  // first hit at edge E0, second at E1, time_ref at Em (m >= 2)
  task automatic measure(input logic [7:0] h0, input logic [7:0] h1, input int m);
    disc_hit = h0;
    @(negedge clk);
    disc_hit = h1;
    @(negedge clk);
    disc_hit = '0;
    repeat (m - 2) @(negedge clk);
    time_ref = 1'b1;
    @(negedge clk);
    time_ref = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 req", req, 0);
    check("R1 word", word_out, 0);
  endtask

  task automatic t_basic();
    group_addr = 4'h5; osc_div = 4'd1;
    measure(8'h04, 8'h00, 7);
    check("R4 req", req, 1);
    check("R2 R4 R5 word", word_out, mk(4'h5, 3, 8'h04));
    repeat (3) @(negedge clk);
    check("R8 req held", req, 1);
    do_ack();
    check("R8 req cleared", req, 0);
    check("R8 word cleared", word_out, 0);
  endtask

  task automatic t_accum();
    group_addr = 4'hA; osc_div = 4'd0;
    measure(8'h01, 8'h80, 4);
    check("R3 word", word_out, mk(4'hA, 3, 8'h81));
    disc_hit = 8'h10; time_ref = 1'b1; group_addr = 4'h3;
    @(negedge clk);
    disc_hit = '0; time_ref = 1'b0; group_addr = 4'hA;
    @(negedge clk);
    check("R7 word frozen", word_out, mk(4'hA, 3, 8'h81));
    do_ack();
  endtask

  task automatic t_div();
    group_addr = 4'h2; osc_div = 4'd3;
    measure(8'h40, 8'h00, 14);
    check("R5 div4", word_out, mk(4'h2, 3, 8'h40));
    do_ack();
    osc_div = 4'd0;
    measure(8'h08, 8'h00, 5);
    check("R5 div1", word_out, mk(4'h2, 4, 8'h08));
    do_ack();
  endtask

  task automatic t_sat();
    group_addr = 4'hF; osc_div = 4'd0;
    measure(8'hFF, 8'h00, 300);
    check("R6 saturate", word_out, mk(4'hF, 255, 8'hFF));
    do_ack();
    check("R8 idle count", word_out, 0);
  endtask

  task automatic t_inject();
    group_addr = 4'h7; osc_div = 4'd0;
    test_en = 8'h22; test_pulse = 1'b1; strobe = 1'b0;
    @(negedge clk);
    test_pulse = 1'b0;
    @(negedge clk);
    check("R9 no strobe req", req, 0);
    check("R9 no strobe word", word_out, 0);
    test_pulse = 1'b1; strobe = 1'b1;
    @(negedge clk);
    test_pulse = 1'b0; strobe = 1'b0;
    @(negedge clk);
    time_ref = 1'b1;
    @(negedge clk);
    time_ref = 1'b0;
    check("R9 injected word", word_out, mk(4'h7, 1, 8'h22));
    do_ack();
    test_en = '0;
  endtask

  task automatic t_idle_ignore();
    time_ref = 1'b1; ack = 1'b1;
    @(negedge clk);
    time_ref = 1'b0; ack = 1'b0;
    @(negedge clk);
    check("R10 req", req, 0);
    check("R10 word", word_out, 0);
  endtask

  initial begin
    rst = 1'b1; group_addr = '0; osc_div = '0; disc_hit = '0; test_en = '0;
    test_pulse = 1'b0; strobe = 1'b0; time_ref = 1'b0; ack = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_basic();
    t_accum();
    t_div();
    t_sat();
    t_inject();
    t_idle_ignore();
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CYC * 20000);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule